// File: doc/BRIEF.md
# Bus Access Cycle Timer

This block sets the length of each processor bus access from the access's 24-bit address. It counts that length out in master-clock cycles. When a start strobe arrives while the block is idle, it classifies the address into one of three access lengths: 6, 8 or 12 cycles. It latches that length and holds a busy flag for exactly that many cycles. A one-cycle done pulse marks the final cycle of the access. One address region has a length that software can choose through a speed-control bit. That bit is read at the moment an access is accepted, so an access already under way keeps the length it started with.

The sequencer is a three-state machine:
- `ST_IDLE` waits for a start strobe (transition *accept*, into `ST_COUNT`).
- `ST_COUNT` decrements the loaded length every cycle. When two cycles remain it moves on (transition *last*, into `ST_FINAL`).
- `ST_FINAL` raises done for one cycle and then returns unconditionally (transition *retire*, into `ST_IDLE`).

Start strobes seen in `ST_COUNT` or `ST_FINAL` are discarded.

Top module: `bus_cycle_timer`

## Requirements
- R1: When address bit 23 is 1 and bit 22 or bit 15 is 1, the access length is the selectable value: 6 when the speed bit is 1 and 8 when it is 0.
- R2: When address bit 23 is 0 and bit 22 or bit 15 is 1, the access length is 8.
- R3: Otherwise, if bit 14 of (addr[15:0] + 0x6000) is 1, the access length is 8.
- R4: Otherwise, if any of bits 14..9 of (addr[15:0] - 0x4000), taken modulo 2^16, is 1, the access length is 6.
- R5: Every other address gives an access length of 12.
- R6: A cycle with `spd_we`=1 loads `spd_val` into the speed bit at that clock edge. An access accepted on the same edge still uses the old value.
- R7: While reset is held and directly after it: `busy`=0, `done`=0, `cyc_len`=0, and the speed bit is 0.
- R8: `cyc_len` shows the latched length from the cycle after an accepted start. It holds that value until the next accepted start.
- R9: After a start accepted at an edge, `busy` is 1 for exactly `cyc_len` cycles, beginning in the following cycle.
- R10: A start strobe while `busy`=1 (including the done cycle) is ignored. It changes neither `cyc_len` nor the length of the busy period.
- R11: Writing the speed bit during an access does not change that access's length. The new value applies from the next accepted start.
- R12: `done` is 1 for exactly one cycle per access: the last cycle in which `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access-start strobe |
| addr | input | 24 | Address of the access being started |
| spd_we | input | 1 | Write strobe for the speed bit |
| spd_val | input | 1 | New speed bit value (1 = fast) |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| cyc_len | output | 4 | Latched access length in cycles |

## Verification
`cyc_len` and `busy` change one cycle after the start edge. `done` appears in the cycle `cyc_len` - 1 after that. A speed write takes effect at the edge where it is sampled.

The bench drives inputs on the falling edge. It advances a behavioural model by the same inputs at each rising edge, then compares all three outputs with the model at the next falling edge. Every cycle is therefore checked exactly where the result is due, including the cycles where strobes are being ignored.

// File: rtl/bct_pkg.sv
package bct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FINAL = 2'd2
    } bct_state_e;
endpackage

// File: rtl/bct_region_decode.sv
module bct_region_decode #(
    parameter int ADDR_W   = 24,
    parameter int CNT_W    = 4,
    parameter int FAST_LEN = 6,
    parameter int SLOW_LEN = 8,
    parameter int LONG_LEN = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast_sel,
    output logic [CNT_W-1:0]  len
);
    localparam int TOP_BIT  = ADDR_W - 1;
    localparam int HIGH_BIT = ADDR_W - 2;

    logic [15:0] lo_plus;
    logic [15:0] lo_minus;
    logic        upper_hit;
    logic [CNT_W-1:0] sel_len;

    always_comb begin
        lo_plus   = addr[15:0] + 16'h6000;
        lo_minus  = addr[15:0] - 16'h4000;
        upper_hit = addr[HIGH_BIT] | addr[15];
        sel_len   = fast_sel ? CNT_W'(FAST_LEN) : CNT_W'(SLOW_LEN);
        if (upper_hit) begin
            len = addr[TOP_BIT] ? sel_len : CNT_W'(SLOW_LEN);
        end else if (lo_plus[14]) begin
            len = CNT_W'(SLOW_LEN);
        end else if (|lo_minus[14:9]) begin
            len = CNT_W'(FAST_LEN);
        end else begin
            len = CNT_W'(LONG_LEN);
        end
    end
endmodule

// File: rtl/bct_speed_reg.sv
module bct_speed_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic val,
    output logic fast
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast <= 1'b0;
        end else if (we) begin
            fast <= val;
        end
    end
endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
    import bct_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len_in,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] len_q
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(2);

    bct_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                cnt_q <= len_in;
                len_q <= len_in;
            end else if (state_q == ST_COUNT) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                busy = 1'b1;
                if (cnt_q == LAST_CNT) state_d = ST_FINAL;
            end
            ST_FINAL: begin
                busy    = 1'b1;
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
    parameter int ADDR_W   = 24,
    parameter int CNT_W    = 4,
    parameter int FAST_LEN = 6,
    parameter int SLOW_LEN = 8,
    parameter int LONG_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              spd_we,
    input  logic              spd_val,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cyc_len
);
    logic             fast_q;
    logic [CNT_W-1:0] dec_len;

    bct_speed_reg u_speed (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (spd_we),
        .val   (spd_val),
        .fast  (fast_q)
    );

    bct_region_decode #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .FAST_LEN (FAST_LEN),
        .SLOW_LEN (SLOW_LEN),
        .LONG_LEN (LONG_LEN)
    ) u_decode (
        .addr     (addr),
        .fast_sel (fast_q),
        .len      (dec_len)
    );

    bct_sequencer #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len_in (dec_len),
        .busy   (busy),
        .done   (done),
        .len_q  (cyc_len)
    );
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cyc_len
);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cyc_len));

    // R9
    end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R1
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_len == 4'd6 || cyc_len == 4'd8 || cyc_len == 4'd12));
endmodule

bind bus_cycle_timer bct_checker #(.CNT_W(CNT_W)) u_bct_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .cyc_len (cyc_len)
);

// File: tb/tb_bus_cycle_timer.sv
`timescale 1ns/1ps
module tb_bus_cycle_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic        spd_we = 1'b0;
    logic        spd_val = 1'b0;
    logic        busy;
    logic        done;
    logic [3:0]  cyc_len;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag = "R9";
    string len_tag = "R7";

    int m_rem = 0;
    int m_len = 0;
    int m_spd = 0;

    always #4 clk = ~clk;

    bus_cycle_timer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .spd_we(spd_we), .spd_val(spd_val),
        .busy(busy), .done(done), .cyc_len(cyc_len)
    );

    function automatic int ref_len(int a, int spd);
        if ((a & 'h408000) != 0) begin
            if ((a & 'h800000) != 0) return spd ? 6 : 8;
            return 8;
        end
        if (((a + 'h6000) & 'h4000) != 0) return 8;
        if (((a - 'h4000) & 'h7e00) != 0) return 6;
        return 12;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit st, int a, bit we, bit v);
        start = st; addr = a[23:0]; spd_we = we; spd_val = v;
        @(posedge clk);
        if (!rst_n) begin
            m_rem = 0; m_len = 0; m_spd = 0;
        end else begin
            if (m_rem > 0) m_rem--;
            else if (st) begin
                m_len = ref_len(a, m_spd);
                m_rem = m_len;
            end
            if (we) m_spd = v;
        end
        @(negedge clk);
        check(tag, int'(busy), (m_rem > 0) ? 1 : 0, "busy");
        check("R12", int'(done), (m_rem == 1) ? 1 : 0, "done");
        check(len_tag, int'(cyc_len), m_len, "cyc_len");
        start = 1'b0; spd_we = 1'b0;
    endtask

    task automatic access(int a, string ltag);
        len_tag = ltag;
        step(1'b1, a, 1'b0, 1'b0);
        len_tag = "R8";
        while (busy) step(1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R7"; len_tag = "R7";
        for (int i = 0; i < 3; i++) step(1'b1, 'h808000, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 1'b0);
        tag = "R9";
        // speed bit 0 after reset: fast region takes 8 (R7, R1)
        access('h808000, "R1");
        access('hC00000, "R1");
        access('h7E0000, "R2");
        access('h00C000, "R2");
        access('h001234, "R3");
        access('h000000, "R3");
        access('h002100, "R4");
        access('h005FFF, "R4");
        access('h003000, "R4");
        access('h004016, "R5");
        access('h0041FF, "R5");
        access('h804000, "R5");
        // R6: set fast, then fast region takes 6
        len_tag = "R6";
        step(1'b0, 0, 1'b1, 1'b1);
        access('h808000, "R6");
        access('hC01234, "R1");
        access('h408000, "R2");
        // R6: write on the same edge as start uses the old value
        tag = "R6"; len_tag = "R6";
        step(1'b1, 'h808000, 1'b1, 1'b0);
        while (busy) step(1'b0, 0, 1'b0, 1'b0);
        access('h808000, "R6");
        // R11: change speed mid-access
        step(1'b0, 0, 1'b1, 1'b1);
        tag = "R11"; len_tag = "R11";
        step(1'b1, 'h808000, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        while (busy) step(1'b0, 0, 1'b0, 1'b0);
        access('h808000, "R11");
        // R10: strobes while busy, including the done cycle
        tag = "R10"; len_tag = "R10";
        step(1'b1, 'h004016, 1'b0, 1'b0);
        step(1'b1, 'h002100, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 'h7E0000, 1'b0, 1'b0);
        while (!done) step(1'b0, 0, 1'b0, 1'b0);
        step(1'b1, 'h002100, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        // R9: back-to-back accepted start right after busy falls
        tag = "R9";
        access('h002100, "R8");
        access('h001234, "R8");
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule